// File: doc/BRIEF.md
# Slot Reset Output Timing Controller

This block produces the active-low reset for one downstream slot and orders it against the slot's power. It has two operating modes. In power-enable mode the reset is a side effect of the slot power control bit: turning power on starts the supply first and releases reset after a programmed delay. Turning power off pulls reset low at once and removes the supply after a second programmed delay. In power-good mode the reset instead tracks an external power-good indication. Reset is released only after that indication has stayed high for the programmed on-delay.

Both modes share a hardware floor on the reset pulse width. Once reset is low it stays low until a parameterised number of timebase ticks has gone by. All delays count ticks of an external timebase strobe, not clock cycles. After chip reset the pin is not driven and behaves as an input. It is driven only once configuration selects the reset function for it. The mode input is configuration and is meant to change only while the block is held in reset.

Top module: `slot_rst_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `slot_rst_n`, `pwr_en` and `rst_oe` are all 0.
- R2: `rst_oe` equals the value `pin_cfg_rst` had in the previous cycle, so the pin stays undriven until the reset function is selected.
- R3: With `rst_mode`=0 (power-enable) and continuous ticks, a rise of `pwr_ctl` raises `pwr_en` one cycle later. `slot_rst_n` rises `up_dly`+2 cycles after the drive cycle, provided the minimum width is already met.
- R4: With `rst_mode`=0, a fall of `pwr_ctl` drops `slot_rst_n` one cycle later. `pwr_en` stays high and drops `dn_dly`+2 cycles after the drive cycle (continuous ticks), so reset is always low before power goes away.
- R5: With `rst_mode`=0, `slot_rst_n` is 0 in every cycle where `pwr_en` is 0.
- R6: With `rst_mode`=1 (power-good), `slot_rst_n` is 0 in the cycle after any cycle with `pwr_good` low. It rises only after `pwr_good` has stayed high for `up_dly` ticks, and a low cycle restarts that wait. In this mode `pwr_en` is `pwr_ctl` delayed by one cycle and has no effect on the reset.
- R7: Every low pulse of `slot_rst_n` lasts until at least `MIN_TICKS` ticks have been counted from the edge that asserted it, whatever the controlling input does meanwhile.
- R8: Delays advance only on clock edges where `tick` is 1. A delay of 0 releases or removes on the cycle after the waiting state is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous chip reset |
| rst_mode | input | 1 | 0 = power-enable mode, 1 = power-good mode |
| pwr_ctl | input | 1 | Slot power control bit |
| pwr_good | input | 1 | Slot power-good indication |
| pin_cfg_rst | input | 1 | Pin configured for the reset function |
| tick | input | 1 | Timebase strobe, one cycle wide |
| up_dly | input | DLY_W | Ticks from power on (or power good) to reset release |
| dn_dly | input | DLY_W | Ticks from reset assertion to power removal |
| slot_rst_n | output | 1 | Active-low slot reset level |
| rst_oe | output | 1 | Drive enable for the reset pin |
| pwr_en | output | 1 | Slot power enable |

## Verification
With ticks on every cycle, the bench drives each input at a falling edge and samples one result per falling edge after it. It expects `pwr_en` and the reset assertion one sample later, power removal `dn_dly`+2 samples later, and reset release at max(entry edge + `up_dly`, `MIN_TICKS`) + 2, computed by a bench function. Sampling the exact sample before and the exact sample of each change pins the latency to one cycle. During the random phase the timebase is sparse, and cycle counts no longer predict the result. The bench instead keeps its own count of ticks that cross edges while reset is low and compares it at each release. It also checks the per-cycle rules of R5 and R6 one sample after each stimulus.

// File: rtl/slot_rst_pkg.sv
package slot_rst_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF = 2'd0,
    SEQ_UP  = 2'd1,
    SEQ_ON  = 2'd2,
    SEQ_DN  = 2'd3
  } seq_state_e;

  // Next sequencer state; mode_pg selects power-good tracking.
  function automatic seq_state_e seq_next(
    input seq_state_e st,
    input logic       mode_pg,
    input logic       pwr_ctl,
    input logic       pwr_good,
    input logic       wait_done,
    input logic       width_done
  );
    seq_state_e n;
    n = st;
    if (mode_pg) begin
      if (!pwr_good) n = SEQ_OFF;
      else begin
        case (st)
          SEQ_OFF, SEQ_DN: n = SEQ_UP;
          SEQ_UP:  if (wait_done && width_done) n = SEQ_ON;
          default: n = st;
        endcase
      end
    end else begin
      case (st)
        SEQ_OFF: if (pwr_ctl) n = SEQ_UP;
        SEQ_UP: begin
          if (!pwr_ctl) n = SEQ_DN;
          else if (wait_done && width_done) n = SEQ_ON;
        end
        SEQ_ON:  if (!pwr_ctl) n = SEQ_DN;
        SEQ_DN:  if (wait_done) n = SEQ_OFF;
        default: n = SEQ_OFF;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/slot_tick_timer.sv
module slot_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt;

  // Saturating tick count, cleared by restart.
  function automatic logic [W-1:0] cnt_step(input logic [W-1:0] c,
                                            input logic clr,
                                            input logic stb);
    if (clr) return '0;
    if (stb && (c != CNT_MAX)) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_step(cnt, restart, tick);
  end

  assign done = (cnt >= limit);

  // R8: with no tick and no restart, a finished window stays finished
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart && $stable(limit)) |=> done);

endmodule

// File: rtl/slot_rst_seq.sv
module slot_rst_seq
  import slot_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_pg,
  input  logic       pwr_ctl,
  input  logic       pwr_good,
  input  logic       wait_done,
  input  logic       width_done,
  output seq_state_e state,
  output logic       wait_restart,
  output logic       width_restart
);
  seq_state_e nxt;
  logic       in_window;
  logic       entering_on;

  assign nxt         = seq_next(state, mode_pg, pwr_ctl, pwr_good, wait_done, width_done);
  assign in_window   = (state == SEQ_UP) || (state == SEQ_DN);
  assign entering_on = (nxt == SEQ_ON) && (state != SEQ_ON);

  // Delay window restarts on every state change and outside the windows.
  assign wait_restart  = (state != nxt) || !in_window;
  // Width counter runs only while reset is asserted.
  assign width_restart = (state == SEQ_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_OFF;
    else        state <= nxt;
  end

  // R7: release is gated by the width timer
  assert_release_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entering_on |-> width_done);

  // R8: release is gated by the delay timer
  assert_release_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == SEQ_ON) |-> $past(wait_done));

endmodule

// File: rtl/slot_rst_ctl.sv
module slot_rst_ctl
  import slot_rst_pkg::*;
#(
  parameter int DLY_W     = 16,
  parameter int MIN_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_mode,
  input  logic             pwr_ctl,
  input  logic             pwr_good,
  input  logic             pin_cfg_rst,
  input  logic             tick,
  input  logic [DLY_W-1:0] up_dly,
  input  logic [DLY_W-1:0] dn_dly,
  output logic             slot_rst_n,
  output logic             rst_oe,
  output logic             pwr_en
);
  localparam int             MIN_W   = $clog2(MIN_TICKS + 1);
  localparam logic [MIN_W-1:0] MIN_LIM = MIN_W'(MIN_TICKS);
  localparam int             HOLD_W  = MIN_W + 1;

  seq_state_e       state;
  logic             wait_restart, width_restart;
  logic             wait_done, width_done;
  logic [DLY_W-1:0] wait_limit;
  logic             pwr_ctl_q, oe_q;

  assign wait_limit = (state == SEQ_DN) ? dn_dly : up_dly;

  slot_rst_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pg      (rst_mode),
    .pwr_ctl      (pwr_ctl),
    .pwr_good     (pwr_good),
    .wait_done    (wait_done),
    .width_done   (width_done),
    .state        (state),
    .wait_restart (wait_restart),
    .width_restart(width_restart)
  );

  slot_tick_timer #(.W(DLY_W)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(wait_restart),
    .tick   (tick),
    .limit  (wait_limit),
    .done   (wait_done)
  );

  slot_tick_timer #(.W(MIN_W)) u_width (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(width_restart),
    .tick   (tick),
    .limit  (MIN_LIM),
    .done   (width_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_ctl_q <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      pwr_ctl_q <= pwr_ctl;
      oe_q      <= pin_cfg_rst;
    end
  end

  assign slot_rst_n = (state == SEQ_ON);
  assign rst_oe     = oe_q;
  assign pwr_en     = rst_mode ? pwr_ctl_q : (state != SEQ_OFF);

  // Assertion aid: ticks seen since the reset output went low.
  logic [HOLD_W-1:0] hold_ticks;
  always_ff @(posedge clk) begin
    if (!rst_n)                                   hold_ticks <= '0;
    else if (slot_rst_n)                          hold_ticks <= '0;
    else if (tick && (hold_ticks != {HOLD_W{1'b1}})) hold_ticks <= hold_ticks + 1'b1;
  end

  assert_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_rst_n) |-> (hold_ticks >= HOLD_W'(MIN_TICKS)));

  assert_unpowered_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_mode && !pwr_en) |-> !slot_rst_n);

  assert_reset_before_power_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_mode && $fell(pwr_en)) |-> $past(!slot_rst_n));

  assert_pg_low_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_mode && !pwr_good) |=> !slot_rst_n);

  assert_oe_follows_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rst_oe == $past(pin_cfg_rst)));

endmodule

// File: tb/tb_slot_rst_ctl.sv
module tb_slot_rst_ctl;
  localparam int DLY_W = 8;
  localparam int MINT  = 8;

  logic clk = 1'b0;
  logic rst_n, rst_mode, pwr_ctl, pwr_good, pin_cfg_rst, tick;
  logic [DLY_W-1:0] up_dly, dn_dly;
  logic slot_rst_n, rst_oe, pwr_en;

  int total = 0;
  int bad   = 0;
  int rises = 0;
  logic r_rst [64];
  logic r_pen [64];
  logic r_oe  [64];

  always #2 clk = ~clk;

  slot_rst_ctl #(.DLY_W(DLY_W), .MIN_TICKS(MINT)) dut (
    .clk(clk), .rst_n(rst_n), .rst_mode(rst_mode), .pwr_ctl(pwr_ctl),
    .pwr_good(pwr_good), .pin_cfg_rst(pin_cfg_rst), .tick(tick),
    .up_dly(up_dly), .dn_dly(dn_dly),
    .slot_rst_n(slot_rst_n), .rst_oe(rst_oe), .pwr_en(pwr_en)
  );

  // Sample index of the release, counting from the drive sample (index 0).
  function automatic int exp_release(input int entry_edge, input int dly, input int min_edge);
    int a;
    a = entry_edge + dly;
    if (min_edge > a) a = min_edge;
    return a + 2;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic rec(input int from, input int to);
    for (int c = from; c <= to; c++) begin
      @(negedge clk);
      r_rst[c] = slot_rst_n;
      r_pen[c] = pwr_en;
      r_oe[c]  = rst_oe;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chip_reset(input logic m);
    rst_n = 1'b0; rst_mode = m; pwr_ctl = 1'b0; pwr_good = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic rand_seg(input logic m, input int cycles);
    int   held;
    logic prev_rst, d_tick, d_pg;
    chip_reset(m);
    pin_cfg_rst = 1'b1;
    up_dly = DLY_W'($urandom % 5);
    dn_dly = DLY_W'($urandom % 5);
    held = 0; prev_rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      d_tick = (($urandom % 3) == 0);
      tick = d_tick;
      if (($urandom % 40) == 0) pwr_ctl = ~pwr_ctl;
      if (m && (($urandom % 40) == 0)) pwr_good = ~pwr_good;
      d_pg = pwr_good;
      @(negedge clk);
      if (!prev_rst && !slot_rst_n) held += d_tick;
      if (!prev_rst && slot_rst_n) begin
        rises++;
        total++;
        if (held < MINT) begin
          bad++;
          $display("FAIL R7: pulse ticks got %0d expected >= %0d", held, MINT);
        end
        held = 0;
      end
      if (prev_rst && !slot_rst_n) held = 0;
      if (!m && !pwr_en) chk("R5 unpowered slot in reset", slot_rst_n, 1'b0);
      if (m && !d_pg)    chk("R6 power-good low resets", slot_rst_n, 1'b0);
      prev_rst = slot_rst_n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; rst_mode = 1'b0; pwr_ctl = 1'b0; pwr_good = 1'b0;
    pin_cfg_rst = 1'b0; tick = 1'b1; up_dly = '0; dn_dly = '0;
    idle(3);
    chk("R1 reset level", slot_rst_n, 1'b0);
    chk("R1 power enable", pwr_en, 1'b0);
    chk("R1 pin drive", rst_oe, 1'b0);
    rst_n = 1'b1;
    rec(1, 1);
    chk("R1 first cycle level", r_rst[1], 1'b0);
    chk("R2 pin undriven", r_oe[1], 1'b0);
    pin_cfg_rst = 1'b1;
    rec(1, 1);
    chk("R2 pin driven after config", r_oe[1], 1'b1);
    idle(20);

    // Power-enable mode: power up
    up_dly = 8'd3; dn_dly = 8'd2;
    pwr_ctl = 1'b1;
    rec(1, 8);
    chk("R3 power on", r_pen[1], 1'b1);
    chk("R3 held before delay", r_rst[exp_release(0, 3, 0) - 1], 1'b0);
    chk("R3 release", r_rst[exp_release(0, 3, 0)], 1'b1);
    idle(20);

    // Power down ordering
    pwr_ctl = 1'b0;
    rec(1, 8);
    chk("R4 reset first", r_rst[1], 1'b0);
    chk("R4 power kept", r_pen[1 + 2], 1'b1);
    chk("R4 power removed", r_pen[2 + 2], 1'b0);
    idle(20);

    // Zero delay
    up_dly = 8'd0;
    pwr_ctl = 1'b1;
    rec(1, 4);
    chk("R8 zero delay held", r_rst[1], 1'b0);
    chk("R8 zero delay release", r_rst[exp_release(0, 0, 0)], 1'b1);
    idle(20);

    // Minimum width against a short power blip
    up_dly = 8'd1; dn_dly = 8'd0;
    pwr_ctl = 1'b0;
    rec(1, 1);
    pwr_ctl = 1'b1;
    rec(2, 12);
    chk("R5 blip power off", r_pen[2], 1'b0);
    chk("R7 width held", r_rst[exp_release(2, 1, MINT) - 1], 1'b0);
    chk("R7 width release", r_rst[exp_release(2, 1, MINT)], 1'b1);
    idle(20);

    // Tick gating
    pwr_ctl = 1'b0;
    idle(20);
    up_dly = 8'd2; tick = 1'b0;
    pwr_ctl = 1'b1;
    rec(1, 30);
    chk("R8 no tick no release", r_rst[30], 1'b0);
    chk("R3 power on without ticks", r_pen[1], 1'b1);
    tick = 1'b1;
    rec(31, 34);
    chk("R8 held one tick in", r_rst[32], 1'b0);
    chk("R8 release after ticks", r_rst[33], 1'b1);

    // Power-good mode
    chip_reset(1'b1);
    up_dly = 8'd2;
    idle(20);
    chk("R6 low power-good", slot_rst_n, 1'b0);
    pwr_good = 1'b1;
    rec(1, 6);
    chk("R6 wait", r_rst[exp_release(0, 2, 0) - 1], 1'b0);
    chk("R6 release", r_rst[exp_release(0, 2, 0)], 1'b1);
    idle(20);
    pwr_good = 1'b0;
    rec(1, 1);
    chk("R6 assert on drop", r_rst[1], 1'b0);
    pwr_good = 1'b1;
    rec(2, 12);
    chk("R7 pg width held", r_rst[exp_release(1, 2, MINT) - 1], 1'b0);
    chk("R7 pg width release", r_rst[exp_release(1, 2, MINT)], 1'b1);
    pwr_ctl = 1'b1;
    rec(1, 2);
    chk("R6 power follows control", r_pen[1], 1'b1);
    chk("R6 control no effect on reset", r_rst[1], 1'b1);
    pwr_ctl = 1'b0;
    rec(1, 2);
    chk("R6 power off keeps reset", r_rst[2], 1'b1);
    chk("R6 power off follows", r_pen[1], 1'b0);

    // Power-good glitch restarts the wait
    up_dly = 8'd8;
    idle(20);
    pwr_good = 1'b0;
    rec(1, 1);
    pwr_good = 1'b1;
    rec(2, 3);
    pwr_good = 1'b0;
    rec(4, 4);
    pwr_good = 1'b1;
    rec(5, 16);
    chk("R6 restart held", r_rst[exp_release(4, 8, MINT) - 1], 1'b0);
    chk("R6 restart release", r_rst[exp_release(4, 8, MINT)], 1'b1);

    // Random phases
    rand_seg(1'b0, 4000);
    rand_seg(1'b1, 4000);
    total++;
    if (rises == 0) begin
      bad++;
      $display("FAIL R3: releases got %0d expected > 0", rises);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule